// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that owns a small bank of 8-bit configuration registers. A host on the bus reads or writes one register at a time, addressing it by an offset carried in the command code. It can also move the whole bank in one transfer: a write starts at offset 0 and steps upward, and a read first returns a byte count and then the bytes from offset 0 upward. The register contents are driven out in parallel to the logic they configure. The bank also holds a byte of hardware status latched at power-up and two fixed identification bytes. None of these three can be written.

A write guard protects the bank. Offset 0 bit 0 is a write-enable flag and is clear after reset. While the flag is clear, every write is acknowledged but changes nothing except that flag. The flag is sampled at each START, so a new value governs only the transfers that follow. Offset 0 bit 7 is a one-way lock. Once it is set, every register is frozen until reset, and writes are still acknowledged. The bus lines are oversampled by a system clock through a two-flop synchronizer. The slave drives SDA through a separate output-enable, in open-drain style.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, `cfg_o` equals `RW_INIT` with its byte 0 forced to 00h, and `sda_oe` is low.
- R2: An address byte whose upper seven bits equal `SLAVE_ADDR` is acknowledged. Any other address is not acknowledged, and the slave ignores the bus, with no further ACK and no register change, until the next START.
- R3: A command code with bit 7 = 1 selects a single-byte operation at the offset in bits 6:0. In a write, the following data byte is stored at that offset.
- R4: Offset 0 bit 0 (write enable) resets to 0. While it was 0 at the START of a transfer, writes to all other bits and offsets are acknowledged and ignored. Bit 0 itself stays writable, so it can be set or cleared.
- R5: The write-enable value is sampled at every START. A change made inside one transfer does not govern later bytes of that same transfer.
- R6: A command code with bit 7 = 0 selects a block operation. In a block write, the next byte is a count. The data bytes after it are stored at offsets 0, 1, 2 and upward, whatever the offset bits hold, and a STOP after any whole byte ends the transfer with nothing written past it.
- R7: A block read returns the count of implemented offsets (`NUM_RW`+3) first. It then returns the bytes from offset 0 upward for as long as the host acknowledges.
- R8: A byte read (command write, repeated START, read address) returns the byte at the commanded offset. The host ends the read with a NACK.
- R9: Offset `NUM_RW` reads `strap_i`, offset `NUM_RW`+1 reads `ID_A` and offset `NUM_RW`+2 reads `ID_B`. Writes to these three offsets are acknowledged and ignored.
- R10: Writing offset 0 with bit 7 = 1, while enabled and while bit 0 already holds 1, sets bit 7. From then on, every register, bit 0 included, stays frozen until reset, and writes are still acknowledged.
- R11: Offsets at or above `NUM_RW`+3 read as 00h. Writes to them are acknowledged and ignored.
- R12: Bytes move most-significant bit first. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data value the slave presents |
| sda_oe | output | 1 | High while the slave pulls SDA low |
| strap_i | input | 8 | Status byte latched at power-up, read-only |
| cfg_o | output | NUM_RW*8 | Writable registers, offset 0 in bits 7:0 |

## Verification
The bench builds the block with `NUM_RW` = 6, so nine offsets are implemented. With this size, one block read walks through the writable bytes, the status byte, both identification bytes and one offset beyond the range, and the count byte is checked as 9. The writable bytes start from distinct initial values. This lets the bench tell a register that was skipped, gated or locked apart from one that was written. The bus is clocked at 16 system cycles per SCL period, slow enough for the synchronizer delay, and every write goes through a behavioural model of the enable and lock rules.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        bus_state_e state;
        rx_phase_e  phase;
        logic [3:0] bitcnt;
        logic [7:0] sh;
        logic [6:0] ptr;
        logic       blk;
        logic       rd_go;
        logic       cnt_pend;
        logic       mack;
        logic       en_eff;
        logic       sda_o;
        logic       sda_oe;
    } ctl_s;

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.scl_sh = {s_q.scl_sh[STAGES-2:0], scl_i};
        s_d.sda_sh = {s_q.sda_sh[STAGES-2:0], sda_i};
        s_d.scl_p  = s_q.scl_sh[STAGES-1];
        s_d.sda_p  = s_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_lvl   = s_q.scl_sh[STAGES-1];
    assign sda_lvl   = s_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~s_q.scl_p;
    assign scl_fall  = ~scl_lvl & s_q.scl_p;
    assign start_det = scl_lvl & s_q.scl_p & s_q.sda_p & ~sda_lvl;
    assign stop_det  = scl_lvl & s_q.scl_p & ~s_q.sda_p & sda_lvl;

endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank #(
    parameter int                  NUM_RW  = 6,
    parameter logic [NUM_RW*8-1:0] RW_INIT = '0,
    parameter logic [7:0]          ID_A    = 8'h00,
    parameter logic [7:0]          ID_B    = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [6:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                en_eff_i,
    input  logic [6:0]          rd_addr,
    input  logic [7:0]          strap_i,
    output logic [7:0]          rd_data,
    output logic                en_now_o,
    output logic [NUM_RW*8-1:0] cfg_o
);

    localparam logic [6:0] AD_STRAP = 7'(NUM_RW);
    localparam logic [6:0] AD_IDA   = 7'(NUM_RW + 1);
    localparam logic [6:0] AD_IDB   = 7'(NUM_RW + 2);
    localparam logic [NUM_RW*8-1:0] INIT_V = {RW_INIT[NUM_RW*8-1:8], 8'h00};

    logic [NUM_RW-1:0][7:0] regs_d, regs_q;

    // offset 0: bit 0 write enable, bit 7 permanent lock
    always_comb begin
        regs_d = regs_q;
        if (wr_i && !regs_q[0][7]) begin
            if (wr_addr == 7'd0) begin
                regs_d[0][0] = wr_data[0];
                if (en_eff_i) begin
                    regs_d[0][6:1] = wr_data[6:1];
                    if (regs_q[0][0] && wr_data[7]) regs_d[0][7] = 1'b1;
                end
            end else if (en_eff_i) begin
                for (int i = 1; i < NUM_RW; i++) begin
                    if (wr_addr == 7'(i)) regs_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= INIT_V;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_addr == 7'(i)) rd_data = regs_q[i];
        end
        if (rd_addr == AD_STRAP) rd_data = strap_i;
        if (rd_addr == AD_IDA)   rd_data = ID_A;
        if (rd_addr == AD_IDB)   rd_data = ID_B;
    end

    assign en_now_o = regs_q[0][0];
    assign cfg_o    = regs_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0][7] |=> regs_q[0][7]); // R10
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0][7] |=> $stable(regs_q)); // R10
    AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff_i |=> ($stable(regs_q[NUM_RW-1:1]) && $stable(regs_q[0][7:1]))); // R4

endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0]          SLAVE_ADDR  = 7'h69,
    parameter int                  NUM_RW      = 6,
    parameter logic [NUM_RW*8-1:0] RW_INIT     = '0,
    parameter logic [7:0]          ID_A        = 8'h00,
    parameter logic [7:0]          ID_B        = 8'h00,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_o,
    output logic                sda_oe,
    input  logic [7:0]          strap_i,
    output logic [NUM_RW*8-1:0] cfg_o
);

    localparam int         NUM_REGS = NUM_RW + 3;
    localparam logic [7:0] COUNT_B  = 8'(NUM_REGS);
    localparam ctl_s CTL_RST = '{
        state: ST_IDLE, phase: PH_ADDR, bitcnt: 4'd0, sh: 8'h00, ptr: 7'd0,
        blk: 1'b0, rd_go: 1'b0, cnt_pend: 1'b0, mack: 1'b0, en_eff: 1'b0,
        sda_o: 1'b1, sda_oe: 1'b0
    };

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en, en_now;
    logic [7:0] rd_data, ld_byte;
    ctl_s       c_d, c_q;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smb_reg_bank #(.NUM_RW(NUM_RW), .RW_INIT(RW_INIT), .ID_A(ID_A), .ID_B(ID_B)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wr_addr(c_q.ptr),
        .wr_data(c_q.sh), .en_eff_i(c_q.en_eff), .rd_addr(c_q.ptr),
        .strap_i(strap_i), .rd_data(rd_data), .en_now_o(en_now), .cfg_o(cfg_o)
    );

    always_comb begin
        c_d     = c_q;
        wr_en   = 1'b0;
        ld_byte = c_q.cnt_pend ? COUNT_B : rd_data;
        if (stop_det) begin
            c_d.state  = ST_IDLE;
            c_d.sda_o  = 1'b1;
            c_d.sda_oe = 1'b0;
        end else if (start_det) begin
            c_d.state    = ST_RX;
            c_d.phase    = PH_ADDR;
            c_d.bitcnt   = 4'd0;
            c_d.rd_go    = 1'b0;
            c_d.cnt_pend = 1'b0;
            c_d.en_eff   = en_now;
            c_d.sda_o    = 1'b1;
            c_d.sda_oe   = 1'b0;
        end else begin
            unique case (c_q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        c_d.sh     = {c_q.sh[6:0], sda_lvl};
                        c_d.bitcnt = c_q.bitcnt + 4'd1;
                    end else if (scl_fall && c_q.bitcnt == 4'd8) begin
                        c_d.bitcnt = 4'd0;
                        c_d.state  = ST_RX_ACK;
                        c_d.sda_o  = 1'b0;
                        c_d.sda_oe = 1'b1;
                        unique case (c_q.phase)
                            PH_ADDR: begin
                                if (c_q.sh[7:1] == SLAVE_ADDR) begin
                                    c_d.rd_go    = c_q.sh[0];
                                    c_d.cnt_pend = c_q.sh[0] & c_q.blk;
                                    c_d.phase    = PH_CMD;
                                end else begin
                                    c_d.state  = ST_IDLE;
                                    c_d.sda_o  = 1'b1;
                                    c_d.sda_oe = 1'b0;
                                end
                            end
                            PH_CMD: begin
                                c_d.blk   = ~c_q.sh[7];
                                c_d.ptr   = c_q.sh[7] ? c_q.sh[6:0] : 7'd0;
                                c_d.phase = c_q.sh[7] ? PH_DATA : PH_COUNT;
                            end
                            PH_COUNT: c_d.phase = PH_DATA;
                            default: begin
                                wr_en   = 1'b1;
                                c_d.ptr = c_q.ptr + 7'd1;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        if (c_q.rd_go) begin
                            c_d.state  = ST_TX;
                            c_d.bitcnt = 4'd0;
                            c_d.sh     = ld_byte;
                            c_d.sda_o  = ld_byte[7];
                            c_d.sda_oe = ~ld_byte[7];
                            if (c_q.cnt_pend) c_d.cnt_pend = 1'b0;
                            else              c_d.ptr      = c_q.ptr + 7'd1;
                        end else begin
                            c_d.state  = ST_RX;
                            c_d.sda_o  = 1'b1;
                            c_d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        c_d.bitcnt = c_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (c_q.bitcnt == 4'd8) begin
                            c_d.state  = ST_TX_ACK;
                            c_d.sda_o  = 1'b1;
                            c_d.sda_oe = 1'b0;
                        end else begin
                            c_d.sh     = {c_q.sh[6:0], 1'b0};
                            c_d.sda_o  = c_q.sh[6];
                            c_d.sda_oe = ~c_q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        c_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (c_q.mack) begin
                            c_d.state  = ST_TX;
                            c_d.bitcnt = 4'd0;
                            c_d.sh     = ld_byte;
                            c_d.sda_o  = ld_byte[7];
                            c_d.sda_oe = ~ld_byte[7];
                            if (c_q.cnt_pend) c_d.cnt_pend = 1'b0;
                            else              c_d.ptr      = c_q.ptr + 7'd1;
                        end else begin
                            c_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTL_RST;
        else        c_q <= c_d;
    end

    assign sda_o  = c_q.sda_o;
    assign sda_oe = c_q.sda_oe;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE) |-> !c_q.sda_oe); // R2
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.sda_oe) |-> !$past(scl_lvl)); // R12

endmodule

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;

    localparam int          NRW  = 6;
    localparam int          NREG = NRW + 3;
    localparam logic [47:0] INIT = 48'h3C_F0_A5_0F_FF_5E;
    localparam logic [7:0]  IDA  = 8'h4B;
    localparam logic [7:0]  IDB  = 8'hE2;
    localparam logic [7:0]  STRAP = 8'hA6;
    localparam int          H    = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_o, sda_oe, sda_line;
    logic [7:0] strap = STRAP;
    logic [NRW*8-1:0] cfg;

    assign sda_line = sda_m & ~(sda_oe & ~sda_o);

    smb_cfg_slave #(.SLAVE_ADDR(7'h69), .NUM_RW(NRW), .RW_INIT(INIT),
                    .ID_A(IDA), .ID_B(IDB)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg));

    int n_chk = 0, n_err = 0, clk_chk = 0, clk_err = 0, wd_err = 0;
    logic hold = 1'b1, fin = 1'b0;

    logic [7:0] mdl [NRW];
    logic       mdl_en;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic mdl_write(input int off, input logic [7:0] d);
        logic b0;
        if (mdl[0][7]) return;
        if (off == 0) begin
            b0 = mdl[0][0];
            mdl[0][0] = d[0];
            if (mdl_en) begin
                mdl[0][6:1] = d[6:1];
                if (b0 && d[7]) mdl[0][7] = 1'b1;
            end
        end else if (off < NRW && mdl_en) begin
            mdl[off] = d;
        end
    endtask

    function automatic logic [7:0] mdl_read(input int off);
        if (off < NRW)  return mdl[off];
        if (off == NRW) return STRAP;
        if (off == NRW + 1) return IDA;
        if (off == NRW + 2) return IDB;
        return 8'h00;
    endfunction

    function automatic logic [NRW*8-1:0] mdl_flat();
        logic [NRW*8-1:0] f;
        for (int i = 0; i < NRW; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    // per-clock comparison of the parallel outputs against the model (R3, R4, R10)
    always @(negedge clk) begin
        if (rst_n && !hold && !fin) begin
            clk_chk++;
            if (cfg !== mdl_flat()) begin
                clk_err++;
                $display("FAIL R3 per-clock cfg: actual %h expected %h", cfg, mdl_flat());
            end
        end
    end

    task automatic wt();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
        mdl_en = mdl[0][0];
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt(); wt();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(); scl_m = 1'b1;
        repeat (H/2) @(negedge clk);
        ack = ~sda_line;
        repeat (H/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv(input logic do_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(); scl_m = 1'b1;
            repeat (H/2) @(negedge clk);
            b[i] = sda_line;
            repeat (H/2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = ~do_ack; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    task automatic xfer_write(input logic [7:0] cmd, input logic [7:0] q[$], input string req);
        logic ack;
        int   ptr;
        hold = 1'b1;
        bus_start();
        send(8'hD2, ack); chk({req, " addr ack"}, ack, 1);
        send(cmd, ack);   chk({req, " cmd ack"}, ack, 1);
        ptr = cmd[7] ? int'(cmd[6:0]) : 0;
        foreach (q[i]) begin
            send(q[i], ack); chk({req, " data ack"}, ack, 1);
            if (!(cmd[7] == 1'b0 && i == 0)) begin
                mdl_write(ptr, q[i]);
                ptr++;
            end
        end
        bus_stop();
        hold = 1'b0;
    endtask

    task automatic xfer_read(input logic [7:0] cmd, input int n, input string req,
                             output logic [7:0] got[$]);
        logic ack;
        logic [7:0] b;
        got = {};
        bus_start();
        send(8'hD2, ack); chk({req, " addr ack"}, ack, 1);
        send(cmd, ack);   chk({req, " cmd ack"}, ack, 1);
        bus_start();
        send(8'hD3, ack); chk({req, " read addr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv(i != n - 1, b);
            got.push_back(b);
        end
        bus_stop();
    endtask

    task automatic finish_up();
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors",
                 n_chk + clk_chk, n_err + clk_err + wd_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            wd_err = 1;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [7:0] got[$];
        logic ack;
        for (int i = 0; i < NRW; i++) mdl[i] = INIT[i*8 +: 8];
        mdl[0] = 8'h00;
        mdl_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 cfg after reset", cfg, {INIT[47:8], 8'h00});
        chk("R1 sda_oe after reset", sda_oe, 0);
        hold = 1'b0;

        // R4 write while disabled is acked but ignored
        xfer_write(8'h81, '{8'h55}, "R4");
        chk("R4 byte1 unchanged", cfg[15:8], 8'hFF);

        // R2 foreign address not acked, following bytes ignored
        bus_start();
        send(8'hA4, ack); chk("R2 foreign addr nack", ack, 0);
        send(8'h81, ack); chk("R2 ignored byte nack", ack, 0);
        send(8'h00, ack); chk("R2 ignored byte nack", ack, 0);
        bus_stop();
        chk("R2 cfg untouched", cfg, mdl_flat());

        // R5 enable set inside a block write does not cover its own later bytes
        xfer_write(8'h00, '{8'd2, 8'h01, 8'hA5}, "R5");
        chk("R5 byte0 enable set", cfg[7:0], 8'h01);
        chk("R5 byte1 not written same transfer", cfg[15:8], 8'hFF);

        // R6 block write from offset 0, offset bits ignored, stop early
        xfer_write(8'h05, '{8'd4, 8'h03, 8'h12, 8'h34}, "R6");
        chk("R6 byte0", cfg[7:0], 8'h03);
        chk("R6 byte1", cfg[15:8], 8'h12);
        chk("R6 byte2", cfg[23:16], 8'h34);
        chk("R6 byte3 past stop", cfg[31:24], 8'hA5);

        // R3 indexed byte write, R8/R12 byte read back
        xfer_write(8'h84, '{8'hC3}, "R3");
        chk("R3 byte4 written", cfg[39:32], 8'hC3);
        xfer_read(8'h84, 1, "R8", got);
        chk("R8 R12 byte read offset 4", got[0], 8'hC3);
        xfer_read(8'h82, 1, "R8", got);
        chk("R8 byte read offset 2", got[0], 8'h34);

        // R9 read-only offsets
        xfer_read(8'h86, 1, "R9", got); chk("R9 strap", got[0], STRAP);
        xfer_read(8'h87, 1, "R9", got); chk("R9 ID_A", got[0], IDA);
        xfer_read(8'h88, 1, "R9", got); chk("R9 ID_B", got[0], IDB);
        xfer_write(8'h87, '{8'h00}, "R9");
        xfer_read(8'h87, 1, "R9", got); chk("R9 ID_A after write", got[0], IDA);

        // R11 beyond the implemented range
        xfer_read(8'hC0, 1, "R11", got); chk("R11 read 00", got[0], 8'h00);
        xfer_write(8'hC0, '{8'hFF}, "R11");
        chk("R11 cfg untouched", cfg, mdl_flat());

        // R7 block read: count then every offset, one past the end
        xfer_read(8'h00, NREG + 2, "R7", got);
        chk("R7 count byte", got[0], NREG);
        for (int i = 0; i <= NREG; i++) chk("R7 block data", got[i+1], mdl_read(i));

        // R4 bit 0 clearable, disables others, then re-settable
        xfer_write(8'h80, '{8'h00}, "R4");
        chk("R4 enable cleared", cfg[7:0], 8'h00);
        xfer_write(8'h82, '{8'h99}, "R4");
        chk("R4 byte2 gated", cfg[23:16], 8'h34);
        xfer_write(8'h80, '{8'h7F}, "R4");
        chk("R4 only bit0 set while disabled", cfg[7:0], 8'h01);

        // R10 permanent lock
        xfer_write(8'h80, '{8'h81}, "R10");
        chk("R10 lock set", cfg[7:0], 8'h81);
        xfer_write(8'h81, '{8'h00}, "R10");
        chk("R10 byte1 frozen", cfg[15:8], 8'h12);
        xfer_write(8'h80, '{8'h00}, "R10");
        chk("R10 byte0 frozen", cfg[7:0], 8'h81);
        xfer_write(8'h00, '{8'd2, 8'h00, 8'h00}, "R10");
        chk("R10 block write frozen", cfg, mdl_flat());
        xfer_read(8'h80, 1, "R10", got); chk("R10 read byte0", got[0], 8'h81);

        repeat (20) @(negedge clk);
        finish_up();
    end

endmodule